// File: doc/BRIEF.md
# Serial Receive Byte Queue with Character Timeout

This block buffers received serial bytes between a receive deserializer and a register bus. It is a circular buffer of `DEPTH` bytes with separate read and write pointers and an occupancy count. The deserializer offers bytes on a push strobe. The bus decode pops the oldest byte with a pop strobe and can read the current count at any time.

A programmable trigger level decides when software is told that data is waiting. The block raises a receive-ready flag, and optionally an interrupt, when the fill level reaches the trigger level. Bytes can also sit below the trigger level. In that case a character-time timeout raises the same flag once no new byte has arrived for fifteen character times. The length of one character time is a parameter given in clock cycles.

A write to the queue control byte selects the trigger level and can flush the queue. A byte that arrives while the queue is full is discarded, and the block reports this with an overrun pulse.

Top module: `rxq_top`

## Requirements
- R1: After synchronous reset the count is 0, the ready flag, the interrupt and the overrun pulse are low, and the trigger level is 1.
- R2: Popped bytes leave in the order they were pushed, including across the pointer wrap. `pop_data` shows the oldest byte while the queue is not empty, and `rx_count` gives the number of stored bytes.
- R3: A push strobe is ignored while `rx_en` is 0. The count and the stored data do not change.
- R4: On a control write, bits 7:6 of `ctl_data` select the trigger level: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14.
- R5: A push that brings the count to the trigger level or above sets `rx_full` on that clock edge. If `rx_irq_en` is 1, the same edge also sets `rx_irq`.
- R6: A pop that leaves the count below the trigger level clears `rx_full` and `rx_irq`.
- R7: A push that leaves the count below the trigger level starts or restarts a timer. If no further push arrives, `rx_full` (and `rx_irq` when it is enabled) rises exactly 15*CHAR_CYC cycles after that push edge.
- R8: The timer is cancelled when the queue becomes empty or when the trigger level is reached. No flag rises afterwards from that earlier push.
- R9: A control write with bit 1 of `ctl_data` set empties the queue, resets both pointers, and clears `rx_full` and `rx_irq`. Any push in the same cycle is discarded.
- R10: A pop of an empty queue shows 0 on `pop_data` and changes no state.
- R11: A push to a full queue with no pop in the same cycle is dropped. `overrun` is high for exactly the one cycle after that edge. A push together with a pop at full is accepted.
- R12: `rx_irq` is low in every cycle that follows a cycle with `rx_irq_en` at 0. `rx_full` is not affected by the enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receiver enable; pushes are accepted only while high |
| rx_irq_en | input | 1 | Receive interrupt enable |
| push_valid | input | 1 | Byte strobe from the deserializer |
| push_data | input | 8 | Received byte |
| pop_req | input | 1 | Pop strobe from bus decode |
| pop_data | output | 8 | Oldest byte, 0 when empty |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_data | input | 8 | Control byte: [7:6] trigger select, [1] flush |
| rx_count | output | 5 | Current number of stored bytes |
| rx_full | output | 1 | Receive-ready flag |
| rx_irq | output | 1 | Receive interrupt |
| overrun | output | 1 | One-cycle pulse for a dropped byte |

## Verification
The bench keeps the default depth of 16 and sets CHAR_CYC to 2. This makes the timeout window 30 cycles, so the exact edge where the flag rises can be bracketed cycle by cycle. With every trigger code in turn, the bench fills the queue to capacity from a shifted pointer position, pushes once more into the full queue, and drains it. Each fill level is therefore checked against the computed flag, interrupt and byte order. Directed runs cover timer restart, cancellation, flush, the empty pop and the interrupt enable.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int BYTE_W        = 8;
    localparam int TIMEOUT_CHARS = 15;
    localparam int TRIG_SEL_LSB  = 6;
    localparam int FLUSH_BIT     = 1;
    localparam int LEVEL_W       = 5;

    typedef enum logic [1:0] {
        TRIG_1  = 2'b00,
        TRIG_4  = 2'b01,
        TRIG_8  = 2'b10,
        TRIG_14 = 2'b11
    } trig_sel_e;

    typedef struct packed {
        logic push;
        logic pop;
        logic flush;
    } rxq_op_t;

    function automatic logic [LEVEL_W-1:0] trig_level(trig_sel_e sel);
        case (sel)
            TRIG_1:  return LEVEL_W'(1);
            TRIG_4:  return LEVEL_W'(4);
            TRIG_8:  return LEVEL_W'(8);
            default: return LEVEL_W'(14);
        endcase
    endfunction

endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
    import rxq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr,
    input  logic [BYTE_W-1:0] ctl_data,
    output trig_sel_e         trig_sel,
    output logic              flush
);

    logic unused_ctl_bits;
    assign unused_ctl_bits = ^{ctl_data[5:2], ctl_data[0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            trig_sel <= TRIG_1;
        end else if (ctl_wr) begin
            trig_sel <= trig_sel_e'(ctl_data[TRIG_SEL_LSB +: 2]);
        end
    end

    assign flush = ctl_wr & ctl_data[FLUSH_BIT];

    // R4
    trig_sel_update_chk: assert property (@(posedge clk) disable iff (rst)
        ctl_wr |=> (trig_sel == trig_sel_e'($past(ctl_data[7:6]))));

    // R1
    trig_reset_chk: assert property (@(posedge clk)
        $past(rst) |-> (trig_sel == TRIG_1));

endmodule

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  rxq_op_t           op,
    input  logic              empty,
    input  logic [BYTE_W-1:0] push_data,
    output logic [BYTE_W-1:0] pop_data
);

    logic [BYTE_W-1:0] mem [DEPTH];
    logic [PW-1:0]     wr_ptr;
    logic [PW-1:0]     rd_ptr;

    function automatic logic [PW-1:0] ptr_step(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (op.push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || op.flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            if (op.push) wr_ptr <= ptr_step(wr_ptr);
            if (op.pop)  rd_ptr <= ptr_step(rd_ptr);
        end
    end

    assign pop_data = empty ? '0 : mem[rd_ptr];

    // R9
    ptr_flush_chk: assert property (@(posedge clk) disable iff (rst)
        op.flush |=> (wr_ptr == '0 && rd_ptr == '0));

    // R10
    empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (empty && !op.push && !op.flush) |=> $stable(rd_ptr));

endmodule

// File: rtl/rxq_timer.sv
module rxq_timer #(
    parameter int TICKS = 30,
    localparam int TW   = $clog2(TICKS + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic stop,
    output logic expire
);

    logic          armed_q;
    logic [TW-1:0] tick_q;

    assign expire = armed_q && (tick_q == TW'(TICKS - 1)) && !arm && !stop;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q <= 1'b0;
            tick_q  <= '0;
        end else if (arm) begin
            armed_q <= 1'b1;
            tick_q  <= '0;
        end else if (stop || expire) begin
            armed_q <= 1'b0;
            tick_q  <= '0;
        end else if (armed_q) begin
            tick_q  <= tick_q + 1'b1;
        end
    end

    // R7
    tick_bound_chk: assert property (@(posedge clk) disable iff (rst)
        tick_q <= TW'(TICKS - 1));

    // R8
    stop_disarm_chk: assert property (@(posedge clk) disable iff (rst)
        (stop && !arm) |=> !armed_q);

    // R7
    expire_once_chk: assert property (@(posedge clk) disable iff (rst)
        expire |=> !expire);

endmodule

// File: rtl/rxq_level.sv
module rxq_level
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_req,
    input  logic          pop_req,
    input  logic          flush,
    input  trig_sel_e     trig_sel,
    input  logic          expire,
    input  logic          irq_en,
    output rxq_op_t       op,
    output logic [CW-1:0] count,
    output logic          full_flag,
    output logic          irq,
    output logic          overrun,
    output logic          tmr_arm,
    output logic          tmr_stop
);

    logic [CW-1:0] cnt_next;
    logic [CW-1:0] trig_cnt;
    logic          at_cap;
    logic          reach;
    logic          set_evt;
    logic          clr_evt;
    logic          drop;

    assign trig_cnt = CW'(trig_level(trig_sel));
    assign at_cap   = (count == CW'(DEPTH));

    always_comb begin
        op.flush = flush;
        op.pop   = pop_req && (count != '0) && !flush;
        op.push  = push_req && !flush && (!at_cap || op.pop);
        drop     = push_req && !flush && !op.push;
    end

    always_comb begin
        cnt_next = count;
        if (flush) begin
            cnt_next = '0;
        end else begin
            case ({op.push, op.pop})
                2'b10:   cnt_next = count + 1'b1;
                2'b01:   cnt_next = count - 1'b1;
                default: cnt_next = count;
            endcase
        end
    end

    assign reach    = (cnt_next >= trig_cnt);
    assign set_evt  = (op.push && reach) || expire;
    assign clr_evt  = op.pop && !reach;
    assign tmr_arm  = op.push && !reach;
    assign tmr_stop = flush || (cnt_next == '0) || (op.push && reach);

    always_ff @(posedge clk) begin
        if (rst) begin
            count     <= '0;
            full_flag <= 1'b0;
            irq       <= 1'b0;
            overrun   <= 1'b0;
        end else begin
            count   <= cnt_next;
            overrun <= drop;
            if (flush)        full_flag <= 1'b0;
            else if (set_evt) full_flag <= 1'b1;
            else if (clr_evt) full_flag <= 1'b0;
            if (!irq_en || flush)       irq <= 1'b0;
            else if (set_evt)           irq <= 1'b1;
            else if (clr_evt)           irq <= 1'b0;
        end
    end

    // R2
    count_bound_chk: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // R9
    flush_empty_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> (count == '0 && !full_flag && !irq));

    // R12
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_en |=> !irq);

    // R10
    empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
        (pop_req && count == '0 && !push_req && !flush) |=> (count == '0));

    // R11
    overrun_full_chk: assert property (@(posedge clk) disable iff (rst)
        overrun |-> (count == CW'(DEPTH)));

endmodule

// File: rtl/rxq_top.sv
module rxq_top
    import rxq_pkg::*;
#(
    parameter int DEPTH    = 16,
    parameter int CHAR_CYC = 868,
    localparam int CW      = $clog2(DEPTH + 1),
    localparam int TICKS   = TIMEOUT_CHARS * CHAR_CYC
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          rx_en,
    input  logic          rx_irq_en,
    input  logic          push_valid,
    input  logic [7:0]    push_data,
    input  logic          pop_req,
    output logic [7:0]    pop_data,
    input  logic          ctl_wr,
    input  logic [7:0]    ctl_data,
    output logic [CW-1:0] rx_count,
    output logic          rx_full,
    output logic          rx_irq,
    output logic          overrun
);

    trig_sel_e trig_sel;
    logic      flush;
    rxq_op_t   op;
    logic      tmr_arm;
    logic      tmr_stop;
    logic      expire;

    rxq_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .ctl_wr   (ctl_wr),
        .ctl_data (ctl_data),
        .trig_sel (trig_sel),
        .flush    (flush)
    );

    rxq_level #(.DEPTH(DEPTH)) u_level (
        .clk       (clk),
        .rst       (rst),
        .push_req  (push_valid & rx_en),
        .pop_req   (pop_req),
        .flush     (flush),
        .trig_sel  (trig_sel),
        .expire    (expire),
        .irq_en    (rx_irq_en),
        .op        (op),
        .count     (rx_count),
        .full_flag (rx_full),
        .irq       (rx_irq),
        .overrun   (overrun),
        .tmr_arm   (tmr_arm),
        .tmr_stop  (tmr_stop)
    );

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst       (rst),
        .op        (op),
        .empty     (rx_count == '0),
        .push_data (push_data),
        .pop_data  (pop_data)
    );

    rxq_timer #(.TICKS(TICKS)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .arm    (tmr_arm),
        .stop   (tmr_stop),
        .expire (expire)
    );

    // R5
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_irq) |-> rx_full);

    // R3
    rx_disabled_chk: assert property (@(posedge clk) disable iff (rst)
        (!rx_en && !pop_req && !ctl_wr) |=> $stable(rx_count));

endmodule

// File: tb/rxq_top_tb_top.sv
module rxq_top_tb_top;

    localparam int DEPTH = 16;
    localparam int CC    = 2;
    localparam int TMO   = 15 * CC;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_en = 1'b1;
    logic       rx_irq_en = 1'b1;
    logic       push_valid = 1'b0;
    logic [7:0] push_data = '0;
    logic       pop_req = 1'b0;
    logic [7:0] pop_data;
    logic       ctl_wr = 1'b0;
    logic [7:0] ctl_data = '0;
    logic [4:0] rx_count;
    logic       rx_full;
    logic       rx_irq;
    logic       overrun;

    int vectors = 0;
    int errors  = 0;
    logic [7:0] seen_pop;
    bit done = 0;

    always #5 clk = ~clk;

    rxq_top #(.DEPTH(DEPTH), .CHAR_CYC(CC)) dut_i (
        .clk(clk), .rst(rst), .rx_en(rx_en), .rx_irq_en(rx_irq_en),
        .push_valid(push_valid), .push_data(push_data), .pop_req(pop_req),
        .pop_data(pop_data), .ctl_wr(ctl_wr), .ctl_data(ctl_data),
        .rx_count(rx_count), .rx_full(rx_full), .rx_irq(rx_irq), .overrun(overrun)
    );

    task automatic chk(input string req, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input logic pv, input logic [7:0] pd, input logic pr,
                       input logic cw, input logic [7:0] cd);
        push_valid = pv; push_data = pd; pop_req = pr; ctl_wr = cw; ctl_data = cd;
        #1 seen_pop = pop_data;
        @(negedge clk);
        push_valid = 1'b0; pop_req = 1'b0; ctl_wr = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic int trig_of(input int sel);
        return (sel == 0) ? 1 : (sel == 1) ? 4 : (sel == 2) ? 8 : 14;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 count", rx_count, 0);
        chk("R1 full", rx_full, 0);
        chk("R1 irq", rx_irq, 0);
        chk("R1 overrun", overrun, 0);
        cyc(1, 8'h11, 0, 0, 0);
        chk("R1 trigger level 1", rx_full, 1);
        cyc(0, 0, 1, 0, 0);
        chk("R1 pop", seen_pop, 8'h11);

        // R10 empty pop
        cyc(0, 0, 1, 0, 0);
        chk("R10 data", seen_pop, 0);
        chk("R10 count", rx_count, 0);
        chk("R10 full", rx_full, 0);

        // R3 receiver disabled
        rx_en = 1'b0;
        cyc(1, 8'h5A, 0, 0, 0);
        chk("R3 count", rx_count, 0);
        chk("R3 full", rx_full, 0);
        rx_en = 1'b1;

        // R4 R5 R6 R2 R11 sweep over trigger codes
        for (int sel = 0; sel < 4; sel++) begin
            int trg;
            trg = trig_of(sel);
            cyc(0, 0, 0, 1, 8'((sel << 6) | 2));
            chk("R9 count", rx_count, 0);
            for (int k = 0; k < sel + 3; k++) cyc(1, 8'hEE, 0, 0, 0);
            for (int k = 0; k < sel + 3; k++) cyc(0, 0, 1, 0, 0);
            for (int n = 1; n <= DEPTH; n++) begin
                cyc(1, 8'(sel * 40 + n), 0, 0, 0);
                chk("R2 count", rx_count, n);
                chk("R4 R5 full", rx_full, int'(n >= trg));
                chk("R5 irq", rx_irq, int'(n >= trg));
            end
            cyc(1, 8'hFF, 0, 0, 0);
            chk("R11 overrun", overrun, 1);
            chk("R11 count", rx_count, DEPTH);
            cyc(0, 0, 0, 0, 0);
            chk("R11 pulse width", overrun, 0);
            cyc(1, 8'(sel * 40 + 17), 1, 0, 0);
            chk("R11 push+pop data", seen_pop, sel * 40 + 1);
            chk("R11 push+pop count", rx_count, DEPTH);
            chk("R11 no overrun", overrun, 0);
            for (int n = DEPTH; n >= 1; n--) begin
                cyc(0, 0, 1, 0, 0);
                chk("R2 order", seen_pop, sel * 40 + 18 - n);
                chk("R2 count", rx_count, n - 1);
                chk("R6 full", rx_full, int'(n - 1 >= trg));
                chk("R6 irq", rx_irq, int'(n - 1 >= trg));
            end
        end

        // R7 timeout edge, trigger 4
        cyc(0, 0, 0, 1, 8'h42);
        cyc(1, 8'h31, 0, 0, 0);
        idle(TMO - 1);
        chk("R7 before window", rx_full, 0);
        idle(1);
        chk("R7 flag at window", rx_full, 1);
        chk("R7 irq at window", rx_irq, 1);
        // R12 interrupt enable low
        rx_irq_en = 1'b0;
        idle(1);
        chk("R12 irq off", rx_irq, 0);
        chk("R12 flag kept", rx_full, 1);
        rx_irq_en = 1'b1;

        // R7 restart by a second push
        cyc(0, 0, 0, 1, 8'h42);
        cyc(1, 8'h32, 0, 0, 0);
        idle(20);
        cyc(1, 8'h33, 0, 0, 0);
        idle(TMO - 1);
        chk("R7 restart before", rx_full, 0);
        idle(1);
        chk("R7 restart at", rx_full, 1);

        // R12 timeout with enable low
        cyc(0, 0, 0, 1, 8'h42);
        rx_irq_en = 1'b0;
        cyc(1, 8'h34, 0, 0, 0);
        idle(TMO);
        chk("R12 flag", rx_full, 1);
        chk("R12 irq", rx_irq, 0);
        rx_irq_en = 1'b1;

        // R8 cancelled by emptying
        cyc(0, 0, 0, 1, 8'h42);
        cyc(1, 8'h35, 0, 0, 0);
        cyc(0, 0, 1, 0, 0);
        idle(TMO + 5);
        chk("R8 emptied", rx_full, 0);

        // R8 cancelled by reaching trigger
        for (int k = 0; k < 4; k++) cyc(1, 8'(k), 0, 0, 0);
        chk("R8 trigger reached", rx_full, 1);
        cyc(0, 0, 1, 0, 0);
        chk("R6 below trigger", rx_full, 0);
        idle(TMO + 5);
        chk("R8 no late flag", rx_full, 0);
        chk("R8 count", rx_count, 3);

        // R9 flush with simultaneous push
        cyc(1, 8'h77, 0, 1, 8'h02);
        chk("R9 count", rx_count, 0);
        chk("R9 full", rx_full, 0);
        cyc(0, 0, 1, 0, 0);
        chk("R9 data", seen_pop, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule